// File: doc/BRIEF.md
# Dual-Sided Channel Mailbox

This block is a shared-memory mailbox between a host and a coprocessor. It holds seven outbound (send) channels and seven inbound (receive) channels. Each channel owns a single 32-byte message buffer and a two-bit handshake state. Both sides reach every buffer byte and every state through their own byte-wide read/write port. The block does not interpret message content.

A send exchange runs like this. The host fills a send buffer and moves the channel from IDLE to NEW. The coprocessor acknowledges with RCVD. It then overwrites the same buffer with its reply and marks COMPLETE. The host reads the reply and returns the channel to IDLE.

Receive channels run the same four-state cycle with the roles swapped. The block accepts only the state writes that the writing side may legally make. Any other state write is dropped and sets that side's sticky error flag. The block drives two host interrupt causes, "send done" and "receive new", and a doorbell toward the coprocessor.

Top module: `mbox_mailbox`

## Requirements
- R1: After reset, every state is IDLE (0), every buffer byte reads 0, and doneIrq, newIrq, copDoorbell, hostErr and copErr are all low.
- R2: The address is 10 bits, and bits [9:8] select the region: 0 = send buffers, 1 = receive buffers, 2 = send states, 3 = receive states. In a buffer region, byte b of channel c sits at c*32+b. In a state region, the channel is addr[2:0]. Channel 7 does not exist: writes to it are ignored and reads of it return 0.
- R3: Read data is registered. The byte at the address presented in one cycle appears on the read-data port after the next clock edge. Both ports see the same storage, and a state reads as its code zero-extended to 8 bits.
- R4: On a send channel, the host may write only IDLE->NEW and COMPLETE->IDLE. The coprocessor may write only NEW->RCVD and RCVD->COMPLETE. The codes are IDLE=0, NEW=1, RCVD=2, COMPLETE=3.
- R5: On a receive channel, the coprocessor may write only IDLE->NEW and COMPLETE->IDLE. The host may write only NEW->RCVD and RCVD->COMPLETE.
- R6: A state write that R4/R5 do not allow leaves the state unchanged. This includes a value above 3 and a write of the current state. It sets the writing side's error flag (hostErr or copErr) from the next cycle until reset, and it leaves the other side's flag untouched.
- R7: doneIrq is high exactly while at least one send channel is COMPLETE. It follows the state write in the cycle after it.
- R8: newIrq is high exactly while at least one receive channel is NEW.
- R9: copDoorbell is high exactly while at least one send channel is NEW or at least one receive channel is COMPLETE.
- R10: A reply written into a buffer replaces the request in place and is read back by the other side. When both sides write the same buffer byte in one cycle, the host's byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 10 | Host byte address |
| hostWe | input | 1 | Host write enable |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, one cycle after the address |
| copAddr | input | 10 | Coprocessor byte address |
| copWe | input | 1 | Coprocessor write enable |
| copWdata | input | 8 | Coprocessor write byte |
| copRdata | output | 8 | Coprocessor read byte, one cycle after the address |
| doneIrq | output | 1 | Some send channel is COMPLETE |
| newIrq | output | 1 | Some receive channel is NEW |
| copDoorbell | output | 1 | Coprocessor has work: a send channel is NEW or a receive channel is COMPLETE |
| hostErr | output | 1 | Sticky: the host made an illegal state write |
| copErr | output | 1 | Sticky: the coprocessor made an illegal state write |

## Verification
A corrupted channel state shows up at once on the interrupt and doorbell outputs in the cycle after the faulty write. It also shows up on the next state read, one cycle after the address. A transition-check fault appears either as a state that moved when it should have held or as an error flag that rose on the wrong side. A fault in buffer indexing only appears when the other side reads the byte back, so each buffer test writes from one port and reads from the other.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NEW  = 2'd1,
    ST_RCVD = 2'd2,
    ST_DONE = 2'd3
  } chanStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic hostBufWe;
    logic copBufWe;
    logic hostRdState;
    logic copRdState;
    logic hostRdValid;
    logic copRdValid;
  } strobeT;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_CHAN = 7,
  parameter int MSG_BYTES = 32,
  parameter int DATA_W = 8,
  localparam int CHAN_W = $clog2(NUM_CHAN),
  localparam int BYTE_W = $clog2(MSG_BYTES),
  localparam int ADDR_W = 2 + CHAN_W + BYTE_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            hostAddr,
  input  logic                         hostWe,
  input  logic [DATA_W-1:0]            hostWdata,
  input  logic [ADDR_W-1:0]            copAddr,
  input  logic                         copWe,
  input  logic [DATA_W-1:0]            copWdata,
  output logic [NUM_CHAN-1:0][1:0]     sendSt,
  output logic [NUM_CHAN-1:0][1:0]     recvSt,
  output logic                         doneIrq,
  output logic                         newIrq,
  output logic                         copDoorbell,
  output logic                         hostErr,
  output logic                         copErr,
  output strobeT                       strobe
);
  // producer moves: IDLE->NEW, COMPLETE->IDLE
  function automatic logic ownerOk(input logic [1:0] cur, input logic [DATA_W-1:0] v);
    return (cur == ST_IDLE && v == DATA_W'(ST_NEW)) ||
           (cur == ST_DONE && v == DATA_W'(ST_IDLE));
  endfunction
  // consumer moves: NEW->RCVD, RCVD->COMPLETE
  function automatic logic workerOk(input logic [1:0] cur, input logic [DATA_W-1:0] v);
    return (cur == ST_NEW  && v == DATA_W'(ST_RCVD)) ||
           (cur == ST_RCVD && v == DATA_W'(ST_DONE));
  endfunction

  logic [1:0] hostRegion, copRegion;
  logic [CHAN_W-1:0] hostBufCh, copBufCh, hostStCh, copStCh;
  logic hostBufOk, copBufOk, hostStOk, copStOk;
  logic hostStWr, copStWr;

  assign hostRegion = hostAddr[ADDR_W-1 -: 2];
  assign copRegion  = copAddr[ADDR_W-1 -: 2];
  assign hostBufCh  = hostAddr[BYTE_W +: CHAN_W];
  assign copBufCh   = copAddr[BYTE_W +: CHAN_W];
  assign hostStCh   = hostAddr[CHAN_W-1:0];
  assign copStCh    = copAddr[CHAN_W-1:0];
  assign hostBufOk  = 32'(hostBufCh) < NUM_CHAN;
  assign copBufOk   = 32'(copBufCh) < NUM_CHAN;
  assign hostStOk   = 32'(hostStCh) < NUM_CHAN;
  assign copStOk    = 32'(copStCh) < NUM_CHAN;
  assign hostStWr   = hostWe && hostRegion[1] && hostStOk;
  assign copStWr    = copWe && copRegion[1] && copStOk;

  always_comb begin
    strobe.hostBufWe   = hostWe && !hostRegion[1] && hostBufOk;
    strobe.copBufWe    = copWe && !copRegion[1] && copBufOk;
    strobe.hostRdState = hostRegion[1];
    strobe.copRdState  = copRegion[1];
    strobe.hostRdValid = hostRegion[1] ? hostStOk : hostBufOk;
    strobe.copRdValid  = copRegion[1] ? copStOk : copBufOk;
  end

  logic [NUM_CHAN-1:0][1:0] sendNext, recvNext;
  logic [NUM_CHAN-1:0] hostBad, copBad, sendDone, sendNew, recvNew, recvDone;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : gChan
    logic hHitS, cHitS, hHitR, cHitR, hOkS, cOkS, hOkR, cOkR;
    assign hHitS = hostStWr && !hostRegion[0] && 32'(hostStCh) == c;
    assign cHitS = copStWr  && !copRegion[0]  && 32'(copStCh) == c;
    assign hHitR = hostStWr &&  hostRegion[0] && 32'(hostStCh) == c;
    assign cHitR = copStWr  &&  copRegion[0]  && 32'(copStCh) == c;
    assign hOkS  = hHitS && ownerOk(sendSt[c], hostWdata);
    assign cOkS  = cHitS && workerOk(sendSt[c], copWdata);
    assign cOkR  = cHitR && ownerOk(recvSt[c], copWdata);
    assign hOkR  = hHitR && workerOk(recvSt[c], hostWdata);
    assign sendNext[c] = hOkS ? hostWdata[1:0] : (cOkS ? copWdata[1:0] : sendSt[c]);
    assign recvNext[c] = cOkR ? copWdata[1:0] : (hOkR ? hostWdata[1:0] : recvSt[c]);
    assign hostBad[c]  = (hHitS && !hOkS) || (hHitR && !hOkR);
    assign copBad[c]   = (cHitS && !cOkS) || (cHitR && !cOkR);
    assign sendDone[c] = sendSt[c] == ST_DONE;
    assign sendNew[c]  = sendSt[c] == ST_NEW;
    assign recvNew[c]  = recvSt[c] == ST_NEW;
    assign recvDone[c] = recvSt[c] == ST_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sendSt  <= '0;
      recvSt  <= '0;
      hostErr <= 1'b0;
      copErr  <= 1'b0;
    end else begin
      sendSt  <= sendNext;
      recvSt  <= recvNext;
      hostErr <= hostErr | (|hostBad);
      copErr  <= copErr | (|copBad);
    end
  end

  assign doneIrq     = |sendDone;
  assign newIrq      = |recvNew;
  assign copDoorbell = (|sendNew) | (|recvDone);
endmodule

// File: rtl/mbox_data.sv
module mbox_data
  import mbox_pkg::*;
#(
  parameter int NUM_CHAN = 7,
  parameter int MSG_BYTES = 32,
  parameter int DATA_W = 8,
  localparam int CHAN_W = $clog2(NUM_CHAN),
  localparam int BYTE_W = $clog2(MSG_BYTES),
  localparam int ADDR_W = 2 + CHAN_W + BYTE_W,
  localparam int SIDE_SPAN = NUM_CHAN * MSG_BYTES,
  localparam int DEPTH = 2 * SIDE_SPAN,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   strobe,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic [DATA_W-1:0]        hostWdata,
  input  logic [ADDR_W-1:0]        copAddr,
  input  logic [DATA_W-1:0]        copWdata,
  input  logic [NUM_CHAN-1:0][1:0] sendSt,
  input  logic [NUM_CHAN-1:0][1:0] recvSt,
  output logic [DATA_W-1:0]        hostRdata,
  output logic [DATA_W-1:0]        copRdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [IDX_W-1:0] bufIdx(input logic [ADDR_W-1:0] a);
    int v;
    v = int'(a[ADDR_W-2]) * SIDE_SPAN + int'(a[BYTE_W +: CHAN_W]) * MSG_BYTES
      + int'(a[BYTE_W-1:0]);
    return IDX_W'(v);
  endfunction

  function automatic logic [1:0] stPick(input logic [ADDR_W-1:0] a,
                                        input logic [NUM_CHAN-1:0][1:0] s,
                                        input logic [NUM_CHAN-1:0][1:0] r);
    logic [1:0] q;
    q = '0;
    for (int c = 0; c < NUM_CHAN; c++)
      if (32'(a[CHAN_W-1:0]) == c) q = a[ADDR_W-2] ? r[c] : s[c];
    return q;
  endfunction

  logic [IDX_W-1:0] hostIdx, copIdx;
  logic [DATA_W-1:0] hostNext, copNext;
  assign hostIdx = bufIdx(hostAddr);
  assign copIdx  = bufIdx(copAddr);

  always_comb begin
    hostNext = '0;
    copNext  = '0;
    if (strobe.hostRdValid)
      hostNext = strobe.hostRdState ? DATA_W'(stPick(hostAddr, sendSt, recvSt)) : mem[hostIdx];
    if (strobe.copRdValid)
      copNext = strobe.copRdState ? DATA_W'(stPick(copAddr, sendSt, recvSt)) : mem[copIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      hostRdata <= '0;
      copRdata  <= '0;
    end else begin
      hostRdata <= hostNext;
      copRdata  <= copNext;
      if (strobe.copBufWe)  mem[copIdx]  <= copWdata;
      if (strobe.hostBufWe) mem[hostIdx] <= hostWdata;  // host kept on collision
    end
  end
endmodule

// File: rtl/mbox_mailbox.sv
module mbox_mailbox
  import mbox_pkg::*;
#(
  parameter int NUM_CHAN = 7,
  parameter int MSG_BYTES = 32,
  parameter int DATA_W = 8,
  localparam int CHAN_W = $clog2(NUM_CHAN),
  localparam int BYTE_W = $clog2(MSG_BYTES),
  localparam int ADDR_W = 2 + CHAN_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic [ADDR_W-1:0] copAddr,
  input  logic              copWe,
  input  logic [DATA_W-1:0] copWdata,
  output logic [DATA_W-1:0] copRdata,
  output logic              doneIrq,
  output logic              newIrq,
  output logic              copDoorbell,
  output logic              hostErr,
  output logic              copErr
);
  strobeT strobe;
  logic [NUM_CHAN-1:0][1:0] sendSt, recvSt;

  mbox_ctrl #(.NUM_CHAN(NUM_CHAN), .MSG_BYTES(MSG_BYTES), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostWdata(hostWdata),
    .copAddr(copAddr), .copWe(copWe), .copWdata(copWdata),
    .sendSt(sendSt), .recvSt(recvSt),
    .doneIrq(doneIrq), .newIrq(newIrq), .copDoorbell(copDoorbell),
    .hostErr(hostErr), .copErr(copErr), .strobe(strobe)
  );

  mbox_data #(.NUM_CHAN(NUM_CHAN), .MSG_BYTES(MSG_BYTES), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .copAddr(copAddr), .copWdata(copWdata),
    .sendSt(sendSt), .recvSt(recvSt),
    .hostRdata(hostRdata), .copRdata(copRdata)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int NUM_CHAN = 7
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     hostWe,
  input logic                     copWe,
  input logic                     doneIrq,
  input logic                     newIrq,
  input logic                     copDoorbell,
  input logic                     hostErr,
  input logic                     copErr,
  input logic [NUM_CHAN-1:0][1:0] sendSt,
  input logic [NUM_CHAN-1:0][1:0] recvSt
);
  // R6: error flags are sticky
  a_r6_host_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |=> hostErr);
  a_r6_cop_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    copErr |=> copErr);

  // R4 / R5: every legal move advances the state by one step of the cycle
  for (genvar c = 0; c < NUM_CHAN; c++) begin : gStep
    a_r4_send_step: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(sendSt[c]) |-> sendSt[c] == $past(sendSt[c]) + 2'd1);
    a_r5_recv_step: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(recvSt[c]) |-> recvSt[c] == $past(recvSt[c]) + 2'd1);
  end

  // R6: without writes nothing moves
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWe && !copWe) |=> ($stable(sendSt) && $stable(recvSt)));

  // R7 / R8 / R9: who can raise each signal
  a_r7_done_by_cop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> $past(copWe));
  a_r8_new_by_cop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(newIrq) |-> $past(copWe));
  a_r9_bell_by_host: assert property (@(posedge clk) disable iff (!rstN)
    $rose(copDoorbell) |-> $past(hostWe));
endmodule

bind mbox_mailbox mbox_checker #(.NUM_CHAN(NUM_CHAN)) uChk (
  .clk(clk), .rstN(rstN), .hostWe(hostWe), .copWe(copWe),
  .doneIrq(doneIrq), .newIrq(newIrq), .copDoorbell(copDoorbell),
  .hostErr(hostErr), .copErr(copErr), .sendSt(sendSt), .recvSt(recvSt)
);

// File: tb/sim_mbox_mailbox.sv
`timescale 1ns/1ps
module sim_mbox_mailbox;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] hA = '0, cA = '0;
  logic hW = 1'b0, cW = 1'b0;
  logic [7:0] hD = '0, cD = '0;
  logic [7:0] hRd, cRd;
  logic doneIrq, newIrq, copDoorbell, hostErr, copErr;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mbox_mailbox u0 (
    .clk(clk), .rstN(rstN),
    .hostAddr(hA), .hostWe(hW), .hostWdata(hD), .hostRdata(hRd),
    .copAddr(cA), .copWe(cW), .copWdata(cD), .copRdata(cRd),
    .doneIrq(doneIrq), .newIrq(newIrq), .copDoorbell(copDoorbell),
    .hostErr(hostErr), .copErr(copErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit cop, input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    if (cop) begin cA = a; cD = d; cW = 1'b1; end
    else begin hA = a; hD = d; hW = 1'b1; end
    @(negedge clk);
    cW = 1'b0; hW = 1'b0;
  endtask

  task automatic rd(input bit cop, input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    if (cop) cA = a; else hA = a;
    @(negedge clk);
    d = cop ? cRd : hRd;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tReset();
    logic [7:0] d;
    chk("R1 doneIrq", doneIrq, 0);
    chk("R1 newIrq", newIrq, 0);
    chk("R1 doorbell", copDoorbell, 0);
    chk("R1 errors", {hostErr, copErr}, 0);
    rd(0, 10'h204, d); chk("R1 state idle", d, 0);
    rd(1, 10'h123, d); chk("R1 buffer zero", d, 0);
  endtask

  task automatic tBuffer();
    logic [7:0] d;
    wr(0, 10'h045, 8'hA5);
    rd(1, 10'h045, d); chk("R3 cross-port read", d, 8'hA5);
    rd(1, 10'h145, d); chk("R2 recv region separate", d, 0);
  endtask

  task automatic tUnusedChan();
    logic [7:0] d;
    wr(0, 10'h0E0, 8'h77);
    rd(0, 10'h0E0, d); chk("R2 channel 7 buffer ignored", d, 0);
    wr(1, 10'h307, 8'h01);
    rd(0, 10'h307, d); chk("R2 channel 7 state reads 0", d, 0);
    chk("R2 no irq from channel 7", newIrq, 0);
  endtask

  task automatic tSendHandshake();
    logic [7:0] d;
    wr(0, 10'h202, 8'h01);
    chk("R9 doorbell on send NEW", copDoorbell, 1);
    wr(1, 10'h202, 8'h02);
    chk("R9 doorbell drops on RCVD", copDoorbell, 0);
    rd(0, 10'h202, d); chk("R4 state RCVD", d, 2);
    wr(1, 10'h045, 8'h5A);
    wr(1, 10'h202, 8'h03);
    chk("R7 doneIrq on COMPLETE", doneIrq, 1);
    rd(0, 10'h045, d); chk("R10 reply overwrote request", d, 8'h5A);
    wr(0, 10'h202, 8'h00);
    chk("R7 doneIrq clears", doneIrq, 0);
    rd(1, 10'h202, d); chk("R4 back to IDLE", d, 0);
    chk("R4 no error on legal walk", {hostErr, copErr}, 0);
  endtask

  task automatic tHostIllegal();
    logic [7:0] d;
    wr(0, 10'h201, 8'h02);
    rd(0, 10'h201, d); chk("R6 illegal host write ignored", d, 0);
    chk("R6 hostErr set", hostErr, 1);
    chk("R6 copErr untouched", copErr, 0);
    wr(0, 10'h203, 8'h05);
    rd(1, 10'h203, d); chk("R6 out-of-range value ignored", d, 0);
    wr(1, 10'h206, 8'h01);
    rd(0, 10'h206, d); chk("R4 cop cannot post on send", d, 0);
    chk("R6 copErr after cop misuse", copErr, 1);
  endtask

  task automatic tRecvHandshake();
    logic [7:0] d;
    wr(1, 10'h304, 8'h01);
    chk("R8 newIrq on recv NEW", newIrq, 1);
    wr(0, 10'h304, 8'h02);
    chk("R8 newIrq drops on RCVD", newIrq, 0);
    wr(0, 10'h304, 8'h03);
    chk("R9 doorbell on recv COMPLETE", copDoorbell, 1);
    wr(0, 10'h304, 8'h00);
    rd(0, 10'h304, d); chk("R5 host cannot idle recv", d, 3);
    wr(1, 10'h304, 8'h00);
    chk("R9 doorbell drops on IDLE", copDoorbell, 0);
    rd(1, 10'h304, d); chk("R5 recv back to IDLE", d, 0);
  endtask

  task automatic tCopIllegal();
    logic [7:0] d;
    doReset();
    wr(1, 10'h300, 8'h02);
    rd(1, 10'h300, d); chk("R6 illegal cop write ignored", d, 0);
    chk("R6 copErr set", copErr, 1);
    chk("R6 hostErr untouched", hostErr, 0);
    wr(1, 10'h300, 8'h00);
    chk("R6 same-state write keeps flag", copErr, 1);
  endtask

  task automatic sendToDone(input logic [2:0] c);
    wr(0, {7'b1000000, c}, 8'h01);
    wr(1, {7'b1000000, c}, 8'h02);
    wr(1, {7'b1000000, c}, 8'h03);
  endtask

  task automatic tMultiDone();
    sendToDone(3'd0);
    sendToDone(3'd5);
    wr(0, 10'h200, 8'h00);
    chk("R7 doneIrq held by other channel", doneIrq, 1);
    wr(0, 10'h205, 8'h00);
    chk("R7 doneIrq clears when none left", doneIrq, 0);
  endtask

  task automatic tCollide();
    logic [7:0] d;
    @(negedge clk);
    hA = 10'h10A; hD = 8'h11; hW = 1'b1;
    cA = 10'h10A; cD = 8'h22; cW = 1'b1;
    @(negedge clk);
    hW = 1'b0; cW = 1'b0;
    rd(1, 10'h10A, d); chk("R10 host wins collision", d, 8'h11);
  endtask

  task automatic tReReset();
    logic [7:0] d;
    wr(0, 10'h045, 8'h99);
    doReset();
    chk("R1 errors cleared by reset", {hostErr, copErr}, 0);
    rd(1, 10'h045, d); chk("R1 buffer cleared by reset", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBuffer();
    tUnusedChan();
    tSendHandshake();
    tHostIllegal();
    tRecvHandshake();
    tCopIllegal();
    tMultiDone();
    tCollide();
    tReReset();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule